// File: doc/BRIEF.md
# Bit-Vector Stall Trigger Node

This block is one cell in a mesh of stall controllers that sits beside each processing element of a reconfigurable array. A single region of the array may span many cells. Each cell of the region must halt in exactly the same cycle, even though a stall request starts at one cell and takes one clock per hop to reach the others. The node keeps a short vector of future stall events. Bit i of the stored vector means "stall i cycles after the current one", and bit 0 drives the local stall output now.

Each cycle the node merges the vectors it hears from its four neighbours with its own stored vector. A neighbour only counts when its program bit says that it belongs to the same region. The merged value moves one place toward bit 0, because one cycle has passed. The node's own port stall is then added at a programmed latency position. The result is stored and also sent back out to the neighbours.

The latency a region uses must be at least the hop distance across it. With that setting, a stall that starts anywhere in the region reaches every node while its event bit still lies in the future. Every node therefore raises its stall output in the same cycle. Requests from several sources, and the unstalls between them, combine by bitwise OR.

Top module: `stall_vec_node`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the stored vector, so vec_o is all zeros and stall_o is 0 while reset is held and on the first cycle after it.
- R2: stall_o always equals bit 0 of vec_o. With no active source, each clock edge moves vec_o one position toward bit 0, and a zero enters at the top bit.
- R3: When port_stall_i is high at a clock edge and lat_sel_i is one-hot with bit k set, bit k of vec_o is set after that edge. If nothing else is active, stall_o is high exactly k cycles after that edge (k = 0 means in the cycle right after the edge).
- R4: A neighbour whose same_domain_i bit is set has its vector ORed in after a shift of one position toward bit 0. Its bit i+1 lands in stored bit i, and its bit 0 is dropped. The bit order of same_domain_i is: bit 0 north, bit 1 east, bit 2 west, bit 3 south.
- R5: A neighbour whose same_domain_i bit is clear has no effect on vec_o or stall_o, whatever its vector holds.
- R6: The next stored vector is the bitwise OR of the shifted stored vector, every enabled neighbour vector (shifted as in R4), and the local placement from R3.
- R7: vec_o presents the full stored vector that the neighbours receive, and is updated once per clock.
- R8: In two adjacent nodes enabled toward each other, a local stall placed at latency k >= 1 in one node raises stall_o in both nodes in the same cycle. Both stall outputs stay equal in every cycle.
- R9: A port stall held high for N consecutive edges at latency k gives exactly N consecutive stall cycles, starting k cycles after the first edge. stall_o is low again in the cycle after the last of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| north_vec_i | input | VEC_W | Vector from the north neighbour |
| east_vec_i | input | VEC_W | Vector from the east neighbour |
| west_vec_i | input | VEC_W | Vector from the west neighbour |
| south_vec_i | input | VEC_W | Vector from the south neighbour |
| same_domain_i | input | 4 | Program bits that enable each neighbour (0 N, 1 E, 2 W, 3 S) |
| lat_sel_i | input | VEC_W | One-hot latency position for the local stall |
| port_stall_i | input | 1 | Stall request from the local stream port |
| vec_o | output | VEC_W | Stored vector, sent to all neighbours |
| stall_o | output | 1 | Stall the local processing element this cycle |

## Verification
A wrong stored bit shows up on vec_o on the very next clock edge, because the vector is exposed in full. It reaches stall_o after as many cycles as its bit position. A misplaced shift or a dropped mask bit therefore shows up as a stall that is one cycle early or late, or as a stall that is missing. A two-node chain exposes a broken hop alignment as a one-cycle skew between the two stall outputs.

// File: rtl/svn_pkg.sv
package svn_pkg;
   localparam int NUM_DIR = 4;
   typedef enum logic [1:0] {
      DIR_N = 2'd0,
      DIR_E = 2'd1,
      DIR_W = 2'd2,
      DIR_S = 2'd3
   } dir_e;
endpackage

// File: rtl/svn_nbr_merge.sv
module svn_nbr_merge #(
   parameter int VEC_W = 9,
   parameter int N_IN  = 4
) (
   input  logic [N_IN-1:0][VEC_W-1:0] vec_i,
   input  logic [N_IN-1:0]            en_i,
   output logic [VEC_W-1:0]           merged_o
);
   logic [N_IN-1:0][VEC_W-1:0] gated;

   for (genvar d = 0; d < N_IN; d++) begin : g_gate
      assign gated[d] = en_i[d] ? vec_i[d] : '0;
   end

   always_comb begin
      merged_o = '0;
      for (int d = 0; d < N_IN; d++) begin
         merged_o = merged_o | gated[d];
      end
   end
endmodule

// File: rtl/svn_local_place.sv
module svn_local_place #(
   parameter int VEC_W = 9
) (
   input  logic             stall_i,
   input  logic [VEC_W-1:0] sel_i,
   output logic [VEC_W-1:0] placed_o
);
   assign placed_o = stall_i ? sel_i : '0;
endmodule

// File: rtl/svn_vec_reg.sv
module svn_vec_reg #(
   parameter int VEC_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VEC_W-1:0] merged_i,
   input  logic [VEC_W-1:0] local_i,
   output logic [VEC_W-1:0] stored_o
);
   logic [VEC_W-1:0] aged;
   logic [VEC_W-1:0] next_vec;

   assign aged     = (stored_o | merged_i) >> 1;
   assign next_vec = aged | local_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stored_o <= '0;
      else        stored_o <= next_vec;
   end
endmodule

// File: rtl/stall_vec_node.sv
module stall_vec_node
   import svn_pkg::*;
#(
   parameter int VEC_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VEC_W-1:0]   north_vec_i,
   input  logic [VEC_W-1:0]   east_vec_i,
   input  logic [VEC_W-1:0]   west_vec_i,
   input  logic [VEC_W-1:0]   south_vec_i,
   input  logic [NUM_DIR-1:0] same_domain_i,
   input  logic [VEC_W-1:0]   lat_sel_i,
   input  logic               port_stall_i,
   output logic [VEC_W-1:0]   vec_o,
   output logic               stall_o
);
   if (VEC_W < 2) begin : g_bad_width
      $error("stall_vec_node: VEC_W must be at least 2");
   end

   logic [NUM_DIR-1:0][VEC_W-1:0] nbr_vec;
   logic [VEC_W-1:0]              merged;
   logic [VEC_W-1:0]              placed;

   assign nbr_vec[DIR_N] = north_vec_i;
   assign nbr_vec[DIR_E] = east_vec_i;
   assign nbr_vec[DIR_W] = west_vec_i;
   assign nbr_vec[DIR_S] = south_vec_i;

   svn_nbr_merge #(.VEC_W(VEC_W), .N_IN(NUM_DIR)) u_merge (
      .vec_i    (nbr_vec),
      .en_i     (same_domain_i),
      .merged_o (merged)
   );

   svn_local_place #(.VEC_W(VEC_W)) u_place (
      .stall_i  (port_stall_i),
      .sel_i    (lat_sel_i),
      .placed_o (placed)
   );

   svn_vec_reg #(.VEC_W(VEC_W)) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .merged_i (merged),
      .local_i  (placed),
      .stored_o (vec_o)
   );

   assign stall_o = vec_o[0];

   logic past_valid;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   // R2
   shift_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> ((vec_o[VEC_W-2:0] & $past(vec_o[VEC_W-1:1])) == $past(vec_o[VEC_W-1:1])));

   // R5
   quiet_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(!port_stall_i && (merged == '0))) |-> (vec_o == ($past(vec_o) >> 1)));

   // R3
   local_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(port_stall_i)) |-> ((vec_o & $past(lat_sel_i)) == $past(lat_sel_i)));

   // R4
   north_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(same_domain_i[DIR_N]))
      |-> ((vec_o & ($past(north_vec_i) >> 1)) == ($past(north_vec_i) >> 1)));

   // R3
   lat_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_stall_i |-> $onehot0(lat_sel_i));
endmodule

// File: tb/stall_vec_node_bench.sv
`timescale 1ns/1ps
module stall_vec_node_bench;
   localparam int W = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0] n_d, e_d, w_d, s_d, sel_d, psel_d;
   logic [3:0]   dom_d;
   logic         ps_d, pps_d, chain;
   logic [W-1:0] vec_main, vec_peer, main_west;
   logic         stall_main, stall_peer;

   assign main_west = chain ? vec_peer : w_d;

   stall_vec_node #(.VEC_W(W)) u_stall_vec_node (
      .clk(clk), .rst_n(rst_n),
      .north_vec_i(n_d), .east_vec_i(e_d), .west_vec_i(main_west), .south_vec_i(s_d),
      .same_domain_i(dom_d), .lat_sel_i(sel_d), .port_stall_i(ps_d),
      .vec_o(vec_main), .stall_o(stall_main)
   );

   stall_vec_node #(.VEC_W(W)) u_peer (
      .clk(clk), .rst_n(rst_n),
      .north_vec_i('0), .east_vec_i(vec_main), .west_vec_i('0), .south_vec_i('0),
      .same_domain_i(4'b0010), .lat_sel_i(psel_d), .port_stall_i(pps_d),
      .vec_o(vec_peer), .stall_o(stall_peer)
   );

   int n_checks = 0;
   int n_fail = 0;
   logic [W-1:0] exp_v = '0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, expv);
      end
   endtask

   function automatic logic [W-1:0] model_next(input logic [W-1:0] cur);
      logic [W-1:0] m;
      m = '0;
      if (dom_d[0]) m |= n_d;
      if (dom_d[1]) m |= e_d;
      if (dom_d[2]) m |= w_d;
      if (dom_d[3]) m |= s_d;
      return ((cur | m) >> 1) | (ps_d ? sel_d : '0);
   endfunction

   // one clock with model comparison (R2, R6, R7)
   task automatic step(input string req);
      exp_v = model_next(exp_v);
      @(posedge clk);
      @(negedge clk);
      check(vec_main == exp_v, req, vec_main, exp_v);
      check(stall_main == exp_v[0], {req, " R2 stall"}, {8'b0, stall_main}, {8'b0, exp_v[0]});
   endtask

   task automatic idle_inputs();
      n_d = '0; e_d = '0; w_d = '0; s_d = '0; sel_d = '0; ps_d = 1'b0;
   endtask

   initial begin
      idle_inputs();
      dom_d = 4'b0000; psel_d = '0; pps_d = 1'b0; chain = 1'b0;
      repeat (3) @(negedge clk);
      // R1 during reset
      check(vec_main == '0 && stall_main == 1'b0, "R1 reset", vec_main, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(vec_main == '0, "R1 after release", vec_main, '0);

      // R3 latency sweep
      for (int k = 0; k < W; k++) begin
         int first_stall;
         first_stall = -1;
         idle_inputs();
         ps_d = 1'b1; sel_d = W'(1) << k;
         step("R3 place");
         if (stall_main && first_stall < 0) first_stall = 0;
         idle_inputs();
         for (int i = 1; i <= W + 1; i++) begin
            step("R3 decay");
            if (stall_main && first_stall < 0) first_stall = i;
         end
         check(first_stall == k, "R3 stall timing", W'(first_stall), W'(k));
      end

      // R4 / R5 per neighbour, enabled and disabled
      for (int d = 0; d < 4; d++) begin
         for (int en = 0; en < 2; en++) begin
            logic [W-1:0] pat;
            pat = W'($urandom) | W'(2);
            idle_inputs();
            dom_d = en[0] ? (4'b1 << d) : (4'b1111 & ~(4'b1 << d));
            case (d)
               0: n_d = pat;
               1: e_d = pat;
               2: w_d = pat;
               default: s_d = pat;
            endcase
            step(en[0] ? "R4 enabled neighbour" : "R5 masked neighbour");
            if (en[0]) check(vec_main == (pat >> 1), "R4 shifted entry", vec_main, pat >> 1);
            else       check(vec_main == '0, "R5 ignored", vec_main, '0);
            idle_inputs();
            for (int i = 0; i < W; i++) step("R4 drain");
         end
      end

      // R6 merge of several sources with one masked
      idle_inputs();
      dom_d = 4'b1101;
      n_d = 9'b100000100; w_d = 9'b000000100; s_d = 9'b000000100; e_d = 9'b111111111;
      ps_d = 1'b1; sel_d = 9'b000001000;
      step("R6 merge");
      check(vec_main == 9'b010001010, "R6 merged value", vec_main, 9'b010001010);
      idle_inputs();
      for (int i = 0; i < W; i++) step("R6 drain");

      // R9 held stall
      begin
         int cnt, first_s, last_s;
         cnt = 0; first_s = -1; last_s = -1;
         dom_d = 4'b0000;
         for (int i = 0; i < 16; i++) begin
            idle_inputs();
            if (i < 4) begin ps_d = 1'b1; sel_d = 9'b000000100; end
            step("R9 held");
            if (stall_main) begin
               cnt++;
               if (first_s < 0) first_s = i;
               last_s = i;
            end
         end
         check(cnt == 4, "R9 stall count", W'(cnt), W'(4));
         check(first_s == 2 && last_s == 5, "R9 window", W'(last_s), W'(5));
      end

      // R6 / R2 random sweep
      for (int i = 0; i < 300; i++) begin
         n_d = W'($urandom); e_d = W'($urandom); w_d = W'($urandom); s_d = W'($urandom);
         dom_d = 4'($urandom);
         ps_d = 1'($urandom);
         sel_d = W'(1) << ($urandom % W);
         step("R6 random");
      end
      idle_inputs();

      // R1 reset in mid-run
      ps_d = 1'b1; sel_d = 9'b100000000;
      step("R1 preload");
      idle_inputs();
      rst_n = 1'b0;
      #1;
      check(vec_main == '0, "R1 mid-run reset", vec_main, '0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_v = '0;
      @(negedge clk);
      check(vec_main == '0 && stall_main == 1'b0, "R1 after mid reset", vec_main, '0);

      // R8 two-node alignment
      chain = 1'b1; dom_d = 4'b0100;
      for (int k = 1; k < W; k++) begin
         int fm, fp;
         bit skew;
         fm = -1; fp = -1; skew = 1'b0;
         pps_d = 1'b1; psel_d = W'(1) << k;
         @(posedge clk); @(negedge clk);
         pps_d = 1'b0; psel_d = '0;
         if (stall_main) fm = 0;
         if (stall_peer) fp = 0;
         for (int i = 1; i <= W + 3; i++) begin
            @(posedge clk); @(negedge clk);
            if (stall_main != stall_peer) skew = 1'b1;
            if (stall_main && fm < 0) fm = i;
            if (stall_peer && fp < 0) fp = i;
         end
         check(!skew, "R8 no skew", {8'b0, stall_main}, {8'b0, stall_peer});
         check(fm == k && fp == k, "R8 aligned stall", W'(fm), W'(k));
      end
      repeat (W + 3) @(negedge clk);
      chain = 1'b0; dom_d = 4'b0000;
      @(negedge clk);
      exp_v = vec_main;
      check(vec_main == '0, "R8 chain drained", vec_main, '0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule